// File: doc/BRIEF.md
# Configuration Device-Number Capture

This block sits on the address phase of a parallel, PCI-style shared bus and learns its own device number from the traffic it sees. It checks each address phase to see whether it is a type-0 configuration write aimed at this function. The function is identified by a fixed function number set by a parameter. When the check passes, the block copies address bits 15:11 into a read-only device-number field. The register offset that the write targets makes no difference to this. Each capture also raises a pulse for one cycle.

The captured device number and the fixed function number are combined into one 32-bit status word that the surrounding configuration space can return on a read. Software cannot write either field directly. The block does not handle data phases, completions, or any other configuration register.

Top module: `cfg_devnum_capture`

## Requirements
- R1: After reset, the device number is 5'b11111 and the hit pulse is low.
- R2: A capture happens on the clock edge where `addrPhase` is high, `cmd` is 4'b1011 (configuration write), `idsel` is high, `ad[1:0]` is 2'b00 and `ad[10:8]` equals `FUNC_NUM`. At that edge the device number takes the value of `ad[15:11]`, and the new value is visible right after the edge.
- R3: `hitPulse` is high for exactly the one cycle after each capturing edge. Back-to-back captures keep it high across both cycles.
- R4: An address phase whose `ad[10:8]` differs from `FUNC_NUM` leaves the device number unchanged and raises no pulse.
- R5: A command other than 4'b1011 leaves the device number unchanged and raises no pulse. This covers a configuration read (4'b1010) and a memory write (4'b0111).
- R6: An address phase with `idsel` low leaves the device number unchanged and raises no pulse.
- R7: A type-1 access (`ad[1:0]` not 2'b00) leaves the device number unchanged and raises no pulse.
- R8: When `addrPhase` is low, the bus contents are ignored, even if they would otherwise qualify.
- R9: In `statusWord`, bits 7:3 hold the device number, bits 2:0 hold `FUNC_NUM`, and bits 31:8 read as zero. `funcNum` always equals `FUNC_NUM`, which defaults to 3'b000.
- R10: A capture takes place whatever register number is carried in `ad[7:2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrPhase | input | 1 | Marks the cycle that carries an address phase |
| cmd | input | 4 | Bus command for the address phase |
| idsel | input | 1 | Configuration select for this device |
| ad | input | 32 | Multiplexed address/data bus (address content) |
| devNum | output | 5 | Captured device number |
| funcNum | output | 3 | Fixed function number |
| hitPulse | output | 1 | One-cycle pulse after each capture |
| statusWord | output | 32 | Read-back word: {24'b0, devNum, funcNum} |

## Verification
The capture decision is driven with a qualifying write, and then with variants that each break exactly one condition: a wrong function number, a read command, a memory-write command, `idsel` low, a type-1 access, and a strobe held low. A capture that fires in any of these variants shows which term of the decode is missing. Qualifying writes are repeated with device numbers 0, 3, 10, 21 and 31, with different register numbers, and with nonzero upper address bits. These runs separate true bit-field extraction from stuck or shifted bits, and they show whether the register offset or the upper address bits leak into the result. Captures are also run back to back and are followed by an idle cycle, which checks that the hit pulse is exactly one cycle wide.

// File: rtl/devcap_pkg.sv
package devcap_pkg;
  localparam int DEV_W  = 5;
  localparam int FUNC_W = 3;
  localparam int CMD_W  = 4;

  typedef struct packed {
    logic load;  // latch device number this edge
    logic hit;   // raise hit pulse after this edge
  } devcap_strobe_t;
endpackage

// File: rtl/devcap_ctrl.sv
module devcap_ctrl
  import devcap_pkg::*;
#(
  parameter logic [FUNC_W-1:0] FUNC_NUM = '0,
  parameter logic [CMD_W-1:0]  CMD_CFG_WR = 4'b1011,
  parameter int AD_W = 32
) (
  input  logic              addrPhase,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              idsel,
  input  logic [AD_W-1:0]   ad,
  output devcap_strobe_t    strobes
);
  localparam int FUNC_LO = 8;
  localparam int FUNC_HI = FUNC_LO + FUNC_W - 1;

  logic isCfgWrite;
  logic isType0;
  logic funcMatch;
  logic qualify;

  always_comb begin
    isCfgWrite = (cmd == CMD_CFG_WR);
    isType0    = (ad[1:0] == 2'b00);
    funcMatch  = (ad[FUNC_HI:FUNC_LO] == FUNC_NUM);
    qualify    = addrPhase && idsel && isCfgWrite && isType0 && funcMatch;
    strobes.load = qualify;
    strobes.hit  = qualify;
  end
endmodule

// File: rtl/devcap_dpath.sv
module devcap_dpath
  import devcap_pkg::*;
#(
  parameter logic [FUNC_W-1:0] FUNC_NUM = '0,
  parameter logic [DEV_W-1:0]  DEV_RESET = '1,
  parameter int AD_W = 32,
  parameter int WORD_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  devcap_strobe_t     strobes,
  input  logic [AD_W-1:0]    ad,
  output logic [DEV_W-1:0]   devNum,
  output logic [FUNC_W-1:0]  funcNum,
  output logic               hitPulse,
  output logic [WORD_W-1:0]  statusWord
);
  localparam int DEV_LO = 11;
  localparam int DEV_HI = DEV_LO + DEV_W - 1;
  localparam int PAD_W  = WORD_W - DEV_W - FUNC_W;

  logic [DEV_W-1:0] devReg;
  logic             hitReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      devReg <= DEV_RESET;
      hitReg <= 1'b0;
    end else begin
      hitReg <= strobes.hit;
      if (strobes.load) devReg <= ad[DEV_HI:DEV_LO];
    end
  end

  always_comb begin
    devNum     = devReg;
    funcNum    = FUNC_NUM;
    hitPulse   = hitReg;
    statusWord = {{PAD_W{1'b0}}, devReg, FUNC_NUM};
  end

  // R4..R8: the register only moves on an edge that carried a load strobe
  p_hold_unless_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (devReg != $past(devReg)) |-> $past(strobes.load));

  // R2: a load takes the device bits present at that edge
  p_load_value_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (devReg == $past(ad[DEV_HI:DEV_LO])));
endmodule

// File: rtl/cfg_devnum_capture.sv
module cfg_devnum_capture
  import devcap_pkg::*;
#(
  parameter logic [FUNC_W-1:0] FUNC_NUM = 3'b000,
  parameter logic [CMD_W-1:0]  CMD_CFG_WR = 4'b1011,
  parameter logic [DEV_W-1:0]  DEV_RESET = 5'b11111
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         addrPhase,
  input  logic [3:0]   cmd,
  input  logic         idsel,
  input  logic [31:0]  ad,
  output logic [4:0]   devNum,
  output logic [2:0]   funcNum,
  output logic         hitPulse,
  output logic [31:0]  statusWord
);
  devcap_strobe_t strobes;

  devcap_ctrl #(
    .FUNC_NUM(FUNC_NUM), .CMD_CFG_WR(CMD_CFG_WR), .AD_W(32)
  ) i_ctrl (
    .addrPhase(addrPhase), .cmd(cmd), .idsel(idsel), .ad(ad), .strobes(strobes)
  );

  devcap_dpath #(
    .FUNC_NUM(FUNC_NUM), .DEV_RESET(DEV_RESET), .AD_W(32), .WORD_W(32)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ad(ad),
    .devNum(devNum), .funcNum(funcNum), .hitPulse(hitPulse), .statusWord(statusWord)
  );

  // R6: a pulse implies idsel was high at the capturing edge
  p_hit_needs_idsel_r6: assert property (@(posedge clk) disable iff (!rstN)
    hitPulse |-> $past(idsel && addrPhase));

  // R5: a pulse implies the configuration-write command
  p_hit_needs_cmd_r5: assert property (@(posedge clk) disable iff (!rstN)
    hitPulse |-> ($past(cmd) == CMD_CFG_WR));

  // R7 / R4: a pulse implies type 0 and matching function
  p_hit_needs_type0_r7: assert property (@(posedge clk) disable iff (!rstN)
    hitPulse |-> ($past(ad[1:0]) == 2'b00 && $past(ad[10:8]) == FUNC_NUM));

  // R9: read-back word carries the fields and zero padding
  p_word_layout_r9: assert property (@(posedge clk) disable iff (!rstN)
    statusWord == {24'd0, devNum, funcNum} && funcNum == FUNC_NUM);
endmodule

// File: tb/test_cfg_devnum_capture.sv
module test_cfg_devnum_capture;
  logic        clk = 1'b0;
  logic        rstN;
  logic        addrPhase;
  logic [3:0]  cmd;
  logic        idsel;
  logic [31:0] ad;
  logic [4:0]  devNum;
  logic [2:0]  funcNum;
  logic        hitPulse;
  logic [31:0] statusWord;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  cfg_devnum_capture i_cfg_devnum_capture (
    .clk(clk), .rstN(rstN), .addrPhase(addrPhase), .cmd(cmd), .idsel(idsel),
    .ad(ad), .devNum(devNum), .funcNum(funcNum), .hitPulse(hitPulse),
    .statusWord(statusWord)
  );

  localparam logic [3:0] CW = 4'b1011, CR = 4'b1010, MW = 4'b0111;

  function automatic logic [31:0] mkAd(logic [15:0] up, logic [4:0] d,
                                       logic [2:0] f, logic [5:0] r, logic [1:0] t);
    return {up, d, f, r, t};
  endfunction

  // {addrPhase, cmd, idsel, ad, expDev, expHit, reqTag[3:0]}
  function automatic logic [47:0] mkVec(logic ap, logic [3:0] c, logic s, logic [31:0] a,
                                        logic [4:0] d, logic h, logic [3:0] tag);
    return {ap, c, s, a, d, h, tag};
  endfunction

  localparam int NV = 11;
  localparam logic [47:0] VEC [NV] = '{
    mkVec(1, CW, 1, mkAd(16'h0, 5'h0A, 3'd0, 6'h00, 2'b00), 5'h0A, 1, 4'd2),  // R2
    mkVec(0, CW, 1, mkAd(16'h0, 5'h03, 3'd0, 6'h00, 2'b00), 5'h0A, 0, 4'd8),  // R8
    mkVec(1, CW, 1, mkAd(16'h0, 5'h03, 3'd0, 6'h22, 2'b00), 5'h03, 1, 4'd10), // R10
    mkVec(1, CW, 1, mkAd(16'h0, 5'h07, 3'd1, 6'h00, 2'b00), 5'h03, 0, 4'd4),  // R4
    mkVec(1, CR, 1, mkAd(16'h0, 5'h07, 3'd0, 6'h00, 2'b00), 5'h03, 0, 4'd5),  // R5 read
    mkVec(1, CW, 0, mkAd(16'h0, 5'h07, 3'd0, 6'h00, 2'b00), 5'h03, 0, 4'd6),  // R6
    mkVec(1, CW, 1, mkAd(16'h0, 5'h07, 3'd0, 6'h00, 2'b01), 5'h03, 0, 4'd7),  // R7
    mkVec(1, MW, 1, mkAd(16'h0, 5'h07, 3'd0, 6'h00, 2'b00), 5'h03, 0, 4'd5),  // R5 mem wr
    mkVec(1, CW, 1, mkAd(16'h0, 5'h00, 3'd0, 6'h3F, 2'b00), 5'h00, 1, 4'd2),  // R2 zero
    mkVec(1, CW, 1, mkAd(16'h0, 5'h1F, 3'd0, 6'h01, 2'b00), 5'h1F, 1, 4'd3),  // R3 back-to-back
    mkVec(1, CW, 1, mkAd(16'hFFFF, 5'h15, 3'd0, 6'h10, 2'b00), 5'h15, 1, 4'd2) // R2 upper bits
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    addrPhase = 0; cmd = CR; idsel = 0; ad = 32'h0;
  endtask

  initial begin
    #(20 * 5000);
    compared++; mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 0; idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1 / R9 reset state
    check("R1 devNum", {27'd0, devNum}, 32'h1F);
    check("R1 hitPulse", {31'd0, hitPulse}, 32'h0);
    check("R9 funcNum", {29'd0, funcNum}, 32'h0);
    check("R9 statusWord", statusWord, 32'h0000_00F8);

    for (int i = 0; i < NV; i++) begin
      {addrPhase, cmd, idsel, ad} = VEC[i][47:10];
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d devNum vec%0d", VEC[i][3:0], i), {27'd0, devNum}, {27'd0, VEC[i][9:5]});
      check($sformatf("R%0d hitPulse vec%0d", VEC[i][3:0], i), {31'd0, hitPulse}, {31'd0, VEC[i][4]});
    end

    // R3: pulse drops after one cycle with no further capture
    idle();
    @(posedge clk); @(negedge clk);
    check("R3 pulse width", {31'd0, hitPulse}, 32'h0);
    // R9: layout after capture of 0x15, upper bits zero despite upper ad bits
    check("R9 statusWord", statusWord, 32'h0000_00A8);

    // R8: qualifying bus contents without the strobe
    addrPhase = 0; cmd = CW; idsel = 1; ad = mkAd(16'h0, 5'h09, 3'd0, 6'h0, 2'b00);
    @(posedge clk); @(negedge clk);
    check("R8 devNum", {27'd0, devNum}, 32'h15);
    check("R8 hitPulse", {31'd0, hitPulse}, 32'h0);

    // R1: reset during operation restores the default
    idle(); rstN = 0;
    @(posedge clk); @(negedge clk);
    rstN = 1;
    check("R1 devNum after rerun reset", {27'd0, devNum}, 32'h1F);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule